// File: doc/BRIEF.md
# Four-Phase Handshake Memory Adapter

This block lets a self-timed processor core reach two clocked on-chip memories. It has two independent request/acknowledge channels, each using four-phase, return-to-zero, bundled-data signalling. The instruction channel reads bytes from a 4096-byte program store. The data channel reads and writes a 256-byte data store, and a direction line chooses between read and write. The core places its address (and, for writes, its data) on the bundle before it raises the request, and holds it there until the acknowledge rises. Read results stay on the response bus until the next access on that channel.

Each request crosses into the clock domain through a synchronizer chain of `SYNC_STAGES` flops. A per-channel state machine has four states. In IDLE it waits for the synchronized request (transition IDLE→ACCESS). In ACCESS it issues one memory enable and waits for the store's completion flag (ACCESS→ACK_HIGH). In ACK_HIGH it holds the acknowledge high until the synchronized request falls (ACK_HIGH→RETURN). In RETURN, with the acknowledge low, it spends one cycle before a new request can be taken (RETURN→IDLE). The program store image is computed when the design is built: the byte at address a is `a[7:0] XOR {a[11:8],a[11:8]} XOR 8'hA5`.

Top module: `hs_mem_adapter`

## Requirements
- R1: While `rst` is high at a clock edge, both acknowledges are low after that edge, and both state machines return to IDLE.
- R2: With `SYNC_STAGES`=2, an acknowledge rises at the fifth rising clock edge counted from the first edge that samples its request high.
- R3: An acknowledge stays high while its request stays high. With `SYNC_STAGES`=2, it falls at the third edge counted from the first edge that samples the request low.
- R4: An instruction-channel access returns on `i_rdata_o` the byte `a[7:0] ^ {a[11:8],a[11:8]} ^ 8'hA5` for address a.
- R5: A data-channel access with `d_wr_i`=1 stores `d_wdata_i` at `d_addr_i`. An access with `d_wr_i`=0 returns the last byte written to that address.
- R6: On each channel, the read data does not change from the rise of the acknowledge until the request falls.
- R7: A data-channel write leaves `d_rdata_o` at the value of the previous read.
- R8: An acknowledge rises only after the store's completion flag has been set for that access, so a read issued right after a write sees the written byte.
- R9: The two channels work independently and can both be mid-handshake at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Active-high synchronous reset |
| i_req_i | input | 1 | Instruction-channel request (asynchronous) |
| i_addr_i | input | PROG_AW | Instruction fetch address, bundled with the request |
| i_ack_o | output | 1 | Instruction-channel acknowledge |
| i_rdata_o | output | DW | Fetched code byte |
| d_req_i | input | 1 | Data-channel request (asynchronous) |
| d_wr_i | input | 1 | 1 = write, 0 = read |
| d_addr_i | input | DATA_AW | Data address, bundled with the request |
| d_wdata_i | input | DW | Write data, bundled with the request |
| d_ack_o | output | 1 | Data-channel acknowledge |
| d_rdata_o | output | DW | Data-store read result |

## Verification
The bench builds the block with its default parameters: a 12-bit program address, an 8-bit data address, 8-bit bytes and a two-flop synchronizer. With these values the acknowledge timing is fixed at five edges to rise and three edges to fall, and this timing is compared against the design on every clock. The address set includes the top and bottom of the program store and both ends of the data store. The bench also runs handshakes on the two channels at the same time, and issues a request as soon as the previous acknowledge has fallen, which exercises the RETURN→IDLE path.

// File: rtl/hs_mem_pkg.sv
package hs_mem_pkg;

    typedef enum logic [1:0] {
        HS_IDLE     = 2'd0,
        HS_ACCESS   = 2'd1,
        HS_ACK_HIGH = 2'd2,
        HS_RETURN   = 2'd3
    } hs_state_t;

    // Program image generator: byte stored at a 12-bit address.
    function automatic logic [7:0] prog_image(input logic [11:0] a);
        return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'hA5;
    endfunction

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= 1'b0;
                else     chain[0] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= 1'b0;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/hs_chan_fsm.sv
module hs_chan_fsm
    import hs_mem_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_s_i,
    input  logic done_i,
    output logic ack_o,
    output logic mem_en_o
);
    hs_state_t state, state_nx;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= HS_IDLE;
        else     state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            HS_IDLE:     if (req_s_i)  state_nx = HS_ACCESS;
            HS_ACCESS:   if (done_i)   state_nx = HS_ACK_HIGH;
            HS_ACK_HIGH: if (!req_s_i) state_nx = HS_RETURN;
            HS_RETURN:                 state_nx = HS_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        ack_o    = 1'b0;
        mem_en_o = 1'b0;
        unique case (state)
            HS_IDLE:     ;
            HS_ACCESS:   mem_en_o = !done_i;
            HS_ACK_HIGH: ack_o    = 1'b1;
            HS_RETURN:   ;
        endcase
    end
endmodule

// File: rtl/hs_prog_store.sv
module hs_prog_store
    import hs_mem_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_i,
    input  logic [AW-1:0] addr_i,
    output logic [DW-1:0] rdata_o,
    output logic          done_o
);
    logic [11:0] a_img;
    assign a_img = 12'(addr_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_o <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= en_i;
            if (en_i) rdata_o <= DW'(prog_image(a_img));
        end
    end
endmodule

// File: rtl/hs_data_store.sv
module hs_data_store #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_i,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          done_o
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en_i && wr_i) mem[addr_i] <= wdata_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_o <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= en_i;
            if (en_i && !wr_i) rdata_o <= mem[addr_i];
        end
    end
endmodule

// File: rtl/hs_mem_adapter.sv
module hs_mem_adapter #(
    parameter int PROG_AW     = 12,
    parameter int DATA_AW     = 8,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               i_req_i,
    input  logic [PROG_AW-1:0] i_addr_i,
    output logic               i_ack_o,
    output logic [DW-1:0]      i_rdata_o,
    input  logic               d_req_i,
    input  logic               d_wr_i,
    input  logic [DATA_AW-1:0] d_addr_i,
    input  logic [DW-1:0]      d_wdata_i,
    output logic               d_ack_o,
    output logic [DW-1:0]      d_rdata_o
);
    logic i_req_s, i_en, i_done;
    logic d_req_s, d_en, d_done;

    hs_sync #(.STAGES(SYNC_STAGES)) u_i_sync (
        .clk(clk), .rst(rst), .d_i(i_req_i), .q_o(i_req_s));
    hs_sync #(.STAGES(SYNC_STAGES)) u_d_sync (
        .clk(clk), .rst(rst), .d_i(d_req_i), .q_o(d_req_s));

    hs_chan_fsm u_i_fsm (
        .clk(clk), .rst(rst), .req_s_i(i_req_s), .done_i(i_done),
        .ack_o(i_ack_o), .mem_en_o(i_en));
    hs_chan_fsm u_d_fsm (
        .clk(clk), .rst(rst), .req_s_i(d_req_s), .done_i(d_done),
        .ack_o(d_ack_o), .mem_en_o(d_en));

    hs_prog_store #(.AW(PROG_AW), .DW(DW)) u_rom (
        .clk(clk), .rst(rst), .en_i(i_en), .addr_i(i_addr_i),
        .rdata_o(i_rdata_o), .done_o(i_done));

    hs_data_store #(.AW(DATA_AW), .DW(DW)) u_ram (
        .clk(clk), .rst(rst), .en_i(d_en), .wr_i(d_wr_i), .addr_i(d_addr_i),
        .wdata_i(d_wdata_i), .rdata_o(d_rdata_o), .done_o(d_done));
endmodule

// File: rtl/hs_mem_adapter_chk.sv
module hs_mem_adapter_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          i_req,
    input logic          i_ack,
    input logic          i_done,
    input logic [DW-1:0] i_rdata,
    input logic          d_req,
    input logic          d_ack,
    input logic          d_done,
    input logic [DW-1:0] d_rdata
);
    a_r1_reset_drops_ack: assert property (@(posedge clk)
        rst |=> (!i_ack && !d_ack));

    a_r3_i_ack_holds: assert property (@(posedge clk) disable iff (rst)
        (i_ack && i_req) |=> i_ack);
    a_r3_d_ack_holds: assert property (@(posedge clk) disable iff (rst)
        (d_ack && d_req) |=> d_ack);

    a_r8_i_ack_after_done: assert property (@(posedge clk) disable iff (rst)
        $rose(i_ack) |-> $past(i_done));
    a_r8_d_ack_after_done: assert property (@(posedge clk) disable iff (rst)
        $rose(d_ack) |-> $past(d_done));

    a_r2_i_ack_needs_req: assert property (@(posedge clk) disable iff (rst)
        $rose(i_ack) |-> i_req);
    a_r2_d_ack_needs_req: assert property (@(posedge clk) disable iff (rst)
        $rose(d_ack) |-> d_req);

    a_r6_i_rdata_stable: assert property (@(posedge clk) disable iff (rst)
        (i_ack && $past(i_ack)) |-> $stable(i_rdata));
    a_r6_d_rdata_stable: assert property (@(posedge clk) disable iff (rst)
        (d_ack && $past(d_ack)) |-> $stable(d_rdata));
endmodule

bind hs_mem_adapter hs_mem_adapter_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst(rst),
    .i_req(i_req_i), .i_ack(i_ack_o), .i_done(i_done), .i_rdata(i_rdata_o),
    .d_req(d_req_i), .d_ack(d_ack_o), .d_done(d_done), .d_rdata(d_rdata_o));

// File: tb/sim_hs_mem_adapter.sv
`timescale 1ns/1ps
module sim_hs_mem_adapter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        i_req = 1'b0, d_req = 1'b0, d_wr = 1'b0;
    logic [11:0] i_addr = '0;
    logic [7:0]  d_addr = '0, d_wdata = '0;
    logic        i_ack, d_ack;
    logic [7:0]  i_rdata, d_rdata;

    int  n_chk = 0, n_bad = 0;
    bit  finished = 1'b0;
    bit  both_seen = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    hs_mem_adapter u0 (
        .clk(clk), .rst(rst),
        .i_req_i(i_req), .i_addr_i(i_addr), .i_ack_o(i_ack), .i_rdata_o(i_rdata),
        .d_req_i(d_req), .d_wr_i(d_wr), .d_addr_i(d_addr), .d_wdata_i(d_wdata),
        .d_ack_o(d_ack), .d_rdata_o(d_rdata));

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] code_at(input int a);
        return 8'(((a & 255) ^ (((a >> 8) & 15) * 17) ^ 'hA5));
    endfunction

    // Behavioural reference: edges since each request level change
    int  i_cnt = 100, d_cnt = 100;
    bit  i_prev = 1'b0, d_prev = 1'b0;
    bit  i_rose = 1'b0, d_rose = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            i_cnt = 100; d_cnt = 100; i_prev = 0; d_prev = 0; i_rose = 0; d_rose = 0;
        end else begin
            if (i_req != i_prev) begin i_cnt = 1; i_prev = i_req; if (i_req) i_rose = 1; end
            else if (i_cnt < 100) i_cnt++;
            if (d_req != d_prev) begin d_cnt = 1; d_prev = d_req; if (d_req) d_rose = 1; end
            else if (d_cnt < 100) d_cnt++;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            bit ei, ed;
            ei = i_prev ? (i_cnt >= 5) : (i_rose && i_cnt < 3);
            ed = d_prev ? (d_cnt >= 5) : (d_rose && d_cnt < 3);
            // R2 governs the rise, R3 the hold and fall
            check(i_ack === ei, i_prev ? "R2 i_ack" : "R3 i_ack", i_ack, ei);
            check(d_ack === ed, d_prev ? "R2 d_ack" : "R3 d_ack", d_ack, ed);
            if (i_ack && d_ack) both_seen = 1'b1;
        end
    end

    task automatic fetch(input logic [11:0] a);
        @(negedge clk); #1 i_addr = a;
        @(negedge clk); #1 i_req = 1'b1;
        do @(negedge clk); while (i_ack !== 1'b1);
        check(i_rdata == code_at(a), "R4 fetch", i_rdata, code_at(a));
        repeat (3) begin
            @(negedge clk);
            check(i_rdata == code_at(a), "R6 i_rdata hold", i_rdata, code_at(a));
        end
        #1 i_req = 1'b0;
        do @(negedge clk); while (i_ack !== 1'b0);
    endtask

    task automatic daccess(input bit wr, input logic [7:0] a, input logic [7:0] wd,
                           input logic [7:0] exp, input string tag);
        @(negedge clk); #1 d_wr = wr; d_addr = a; d_wdata = wd;
        @(negedge clk); #1 d_req = 1'b1;
        do @(negedge clk); while (d_ack !== 1'b1);
        check(d_rdata == exp, tag, d_rdata, exp);
        repeat (2) begin
            @(negedge clk);
            check(d_rdata == exp, "R6 d_rdata hold", d_rdata, exp);
        end
        #1 d_req = 1'b0;
        do @(negedge clk); while (d_ack !== 1'b0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(i_ack == 1'b0 && d_ack == 1'b0, "R1 reset acks", {i_ack, d_ack}, 0);
        #1 rst = 1'b0;

        // R4: fetches at both ends and inside the program store
        fetch(12'h000); fetch(12'h001); fetch(12'h123); fetch(12'hFFF); fetch(12'h800);

        // R5 / R7 / R8: writes then reads on the data store
        daccess(1, 8'h10, 8'h3C, 8'h00, "R7 write keeps rdata");
        daccess(1, 8'hFF, 8'hC3, 8'h00, "R7 write keeps rdata");
        daccess(1, 8'h00, 8'h81, 8'h00, "R7 write keeps rdata");
        daccess(0, 8'h10, 8'h00, 8'h3C, "R5 read 10");
        daccess(0, 8'hFF, 8'h00, 8'hC3, "R5 read FF");
        daccess(0, 8'h00, 8'h00, 8'h81, "R5 read 00");
        daccess(1, 8'h10, 8'h99, 8'h81, "R7 write after read");
        daccess(0, 8'h10, 8'h00, 8'h99, "R8 read right after write");

        // R9: both channels busy together
        fork
            begin fetch(12'h0AB); fetch(12'h7F0); fetch(12'hF0F); end
            begin
                daccess(1, 8'h55, 8'hAA, 8'h99, "R9 write concurrent");
                daccess(0, 8'h55, 8'h00, 8'hAA, "R9 read concurrent");
                daccess(0, 8'hFF, 8'h00, 8'hC3, "R9 read concurrent");
            end
        join
        check(both_seen, "R9 overlap", both_seen, 1);

        repeat (6) @(negedge clk);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule